// File: doc/BRIEF.md
# Fixed-Point to Pixel Pack Unit

The pack unit narrows intermediate fixed-point lane data down to a smaller format in one registered step. It offers three conversions: four signed 16-bit fixed lanes to four unsigned 8-bit pixels; two signed 32-bit fixed lanes to two 8-bit pixels that are merged into a word already in flight; and 32-bit fixed values to 16-bit fixed values, four at a time, drawn from two source words.

Each lane goes through the same steps at once. The lane is shifted left by a programmable scale, a rounding constant is added one position below the kept field, the fraction bits are dropped, and the result is clamped to the destination range. The scale is a 4-bit field in a small status register that software loads through a write strobe. A caller presents an operation with a mode and up to two 64-bit sources. The packed word appears one clock later together with a valid flag.

Top module: `pack_unit`

## Requirements
- R1: While rst_n is low, result is 0 and result_valid is 0. The scale field resets to 0.
- R2: result_valid is high exactly in the cycle after a cycle with op_valid high, and result is updated at that same edge. When op_valid is low, result_valid falls to 0 and result keeps its previous value whatever the other inputs do.
- R3: When scale_we is high, the next clock edge loads scale_wdata[3:0] into the scale field. An operation presented in the same cycle as a write uses the old scale. The new scale applies from the following cycle on.
- R4: Mode code 0 (pixel-16) treats src_a[16i+15:16i] (i = 0..3) as a signed value v. It computes p = floor((v*2^s + 64) / 128), where s is the scale, clamps p as in R5, and places it at result[8i+7:8i]. result[63:32] is 0.
- R5: In both pixel modes, a lane result below 0 becomes 0 and a lane result above 255 becomes 255. Results from 0 to 255 pass through unchanged.
- R6: Mode code 1 (pixel-32) treats src_a[32j+31:32j] (j = 0..1) as a signed value v. It computes p = floor((v*2^s + 2^22) / 2^23), clamped as in R5. result[32j+31:32j] is {src_b[32j+23:32j], p}: the second source moves up one byte per lane and the pixel fills the low byte.
- R7: Mode code 2 (fix-16) forms four results k = 0..3. Lanes k = 0 and 1 come from src_a[32k+31:32k], and lanes k = 2 and 3 come from src_b[32(k-2)+31:32(k-2)], each read as a signed value v. Each result is floor((v*2^s + 2^15) / 2^16), saturated to the range -32768 to 32767, and placed at result[16k+15:16k].
- R8: Rounding adds one at the bit just below the kept field, so an exact half rounds up (toward plus infinity). Examples: mode 0 with s=0 takes 64 to 1 and -64 to 0. Mode 2 with s=0 takes 0x00008000 to 1 and 0xFFFF8000 to 0.
- R9: Mode code 3 is reserved. An operation in that mode produces result 0 with result_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_we | input | 1 | Write strobe for the scale field |
| scale_wdata | input | 4 | New scale value |
| op_valid | input | 1 | An operation is presented this cycle |
| op_mode | input | 2 | 0 pixel-16, 1 pixel-32, 2 fix-16, 3 reserved |
| src_a | input | 64 | First source word (fixed lanes) |
| src_b | input | 64 | Second source word (merge data or extra fixed lanes) |
| result_valid | output | 1 | result holds a new packed word |
| result | output | 64 | Packed output word |

## Verification
The bench walks all sixteen scale values in every mode. A design that shifted by too few positions, or dropped the top scale bit, would give wrong lanes at the high scales. Directed lanes sit exactly on both clamp edges and one step beyond them, and on exact halves. A design that clipped negatives through an unsigned compare would give 255 where 0 is due, and one that truncated instead of rounding would give 0 where 1 is due. A scale write issued in the same cycle as an operation checks that the operation uses the old scale. Idle cycles with changing inputs check that result holds, and pixel-32 operations check that the second source moves up one byte and does not overwrite the new pixel.

// File: rtl/pack_pkg.sv
package pack_pkg;
  localparam int WORD_W    = 64;
  localparam int SCALE_W   = 4;
  localparam int PIX_W     = 8;

  localparam int P16_IN_W  = 16;
  localparam int P16_FRAC  = 7;
  localparam int P16_LANES = WORD_W / P16_IN_W;

  localparam int P32_IN_W  = 32;
  localparam int P32_FRAC  = 23;
  localparam int P32_LANES = WORD_W / P32_IN_W;

  localparam int FIX_OUT_W = 16;
  localparam int FIX_FRAC  = 16;
  localparam int FIX_LANES = 2 * P32_LANES;

  typedef enum logic [1:0] {
    MODE_PIX16 = 2'd0,
    MODE_PIX32 = 2'd1,
    MODE_FIX   = 2'd2,
    MODE_RSVD  = 2'd3
  } pack_mode_e;
endpackage

// File: rtl/pack_scale_reg.sv
module pack_scale_reg
  import pack_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SCALE_W-1:0] wr_data,
  output logic [SCALE_W-1:0] scale
);
  logic [SCALE_W-1:0] scale_d, scale_q;

  always_comb begin
    scale_d = scale_q;
    if (wr_en) scale_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scale_q <= '0;
    else        scale_q <= scale_d;
  end

  assign scale = scale_q;

  // R3
  scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(scale_q));

  // R3
  scale_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> scale_q == $past(wr_data));
endmodule

// File: rtl/pack_lane.sv
module pack_lane #(
  parameter int IN_W       = 16,
  parameter int FRAC       = 7,
  parameter int OUT_W      = 8,
  parameter bit SIGNED_OUT = 1'b0,
  parameter int SCALE_W    = 4
) (
  input  logic [IN_W-1:0]    lane_in,
  input  logic [SCALE_W-1:0] scale,
  output logic [OUT_W-1:0]   lane_out
);
  localparam int MAX_SHIFT = (1 << SCALE_W) - 1;
  localparam int W         = IN_W + MAX_SHIFT + 2;
  localparam logic signed [W-1:0] RND = (W)'(1) << (FRAC - 1);
  localparam logic signed [W-1:0] HI  = SIGNED_OUT ? (W)'((1 << (OUT_W - 1)) - 1)
                                                   : (W)'((1 << OUT_W) - 1);
  localparam logic signed [W-1:0] LO  = SIGNED_OUT ? ~HI : '0;

  logic signed [W-1:0] ext, shifted, rounded, quot;

  always_comb begin
    ext     = {{(W-IN_W){lane_in[IN_W-1]}}, lane_in};
    shifted = ext <<< scale;
    rounded = shifted + RND;
    quot    = rounded >>> FRAC;
    if (quot > HI)      lane_out = HI[OUT_W-1:0];
    else if (quot < LO) lane_out = LO[OUT_W-1:0];
    else                lane_out = quot[OUT_W-1:0];
  end
endmodule

// File: rtl/pack_unit.sv
module pack_unit
  import pack_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scale_we,
  input  logic [SCALE_W-1:0] scale_wdata,
  input  logic               op_valid,
  input  logic [1:0]         op_mode,
  input  logic [WORD_W-1:0]  src_a,
  input  logic [WORD_W-1:0]  src_b,
  output logic               result_valid,
  output logic [WORD_W-1:0]  result
);
  localparam int KEEP_B = P32_IN_W - PIX_W;

  logic [SCALE_W-1:0] scale;
  logic [WORD_W-1:0]  word_p16, word_p32, word_fix, word_sel;
  logic [WORD_W-1:0]  res_d, res_q;
  logic               vld_d, vld_q;

  pack_scale_reg u_scale (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (scale_we),
    .wr_data (scale_wdata),
    .scale   (scale)
  );

  assign word_p16[WORD_W-1:P16_LANES*PIX_W] = '0;

  for (genvar i = 0; i < P16_LANES; i++) begin : g_p16
    pack_lane #(.IN_W(P16_IN_W), .FRAC(P16_FRAC), .OUT_W(PIX_W),
                .SIGNED_OUT(1'b0), .SCALE_W(SCALE_W)) u_lane (
      .lane_in  (src_a[i*P16_IN_W +: P16_IN_W]),
      .scale    (scale),
      .lane_out (word_p16[i*PIX_W +: PIX_W])
    );
  end

  for (genvar j = 0; j < P32_LANES; j++) begin : g_p32
    pack_lane #(.IN_W(P32_IN_W), .FRAC(P32_FRAC), .OUT_W(PIX_W),
                .SIGNED_OUT(1'b0), .SCALE_W(SCALE_W)) u_lane (
      .lane_in  (src_a[j*P32_IN_W +: P32_IN_W]),
      .scale    (scale),
      .lane_out (word_p32[j*P32_IN_W +: PIX_W])
    );
    assign word_p32[j*P32_IN_W+PIX_W +: KEEP_B] = src_b[j*P32_IN_W +: KEEP_B];
  end

  for (genvar k = 0; k < FIX_LANES; k++) begin : g_fix
    logic [P32_IN_W-1:0] fin;
    if (k < P32_LANES) begin : g_a
      assign fin = src_a[k*P32_IN_W +: P32_IN_W];
    end else begin : g_b
      assign fin = src_b[(k-P32_LANES)*P32_IN_W +: P32_IN_W];
    end
    pack_lane #(.IN_W(P32_IN_W), .FRAC(FIX_FRAC), .OUT_W(FIX_OUT_W),
                .SIGNED_OUT(1'b1), .SCALE_W(SCALE_W)) u_lane (
      .lane_in  (fin),
      .scale    (scale),
      .lane_out (word_fix[k*FIX_OUT_W +: FIX_OUT_W])
    );
  end

  always_comb begin
    case (op_mode)
      MODE_PIX16: word_sel = word_p16;
      MODE_PIX32: word_sel = word_p32;
      MODE_FIX:   word_sel = word_fix;
      default:    word_sel = '0;
    endcase
  end

  always_comb begin
    res_d = res_q;
    vld_d = op_valid;
    if (op_valid) res_d = word_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> result_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!result_valid && $stable(result)));

  // R4
  p16_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == MODE_PIX16) |=> result[63:32] == 32'd0);

  // R6
  p32_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == MODE_PIX32) |=>
      (result[31:8] == $past(src_b[23:0]) && result[63:40] == $past(src_b[55:32])));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == MODE_RSVD) |=> result == 64'd0);
endmodule

// File: tb/tb_pack_unit.sv
`timescale 1ns/1ps
module tb_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scale_we;
  logic [3:0]  scale_wdata;
  logic        op_valid;
  logic [1:0]  op_mode;
  logic [63:0] src_a, src_b;
  logic        result_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          m_scale;
  logic [63:0] exp_res;
  logic        exp_vld;

  always #2 clk = ~clk;

  pack_unit dut (
    .clk(clk), .rst_n(rst_n), .scale_we(scale_we), .scale_wdata(scale_wdata),
    .op_valid(op_valid), .op_mode(op_mode), .src_a(src_a), .src_b(src_b),
    .result_valid(result_valid), .result(result)
  );

  function automatic longint scaled(longint v, int s, int frac);
    longint x;
    x = v * (longint'(1) << s) + (longint'(1) << (frac - 1));
    return x >>> frac;
  endfunction

  function automatic longint clip(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [63:0] model(int mode, logic [63:0] a, logic [63:0] b, int s);
    logic [63:0] r;
    longint v, p;
    r = '0;
    case (mode)
      0: for (int i = 0; i < 4; i++) begin
           v = longint'(shortint'(a[16*i +: 16]));
           p = clip(scaled(v, s, 7), 0, 255);
           r[8*i +: 8] = p[7:0];
         end
      1: for (int j = 0; j < 2; j++) begin
           v = longint'(int'(a[32*j +: 32]));
           p = clip(scaled(v, s, 23), 0, 255);
           r[32*j +: 32] = {b[32*j +: 24], p[7:0]};
         end
      2: for (int k = 0; k < 4; k++) begin
           if (k < 2) v = longint'(int'(a[32*k +: 32]));
           else       v = longint'(int'(b[32*(k-2) +: 32]));
           p = clip(scaled(v, s, 16), -32768, 32767);
           r[16*k +: 16] = p[15:0];
         end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (result_valid !== exp_vld || result !== exp_res) begin
      errors++;
      $display("FAIL %s: actual valid=%0b result=%h expected valid=%0b result=%h",
               tag, result_valid, result, exp_vld, exp_res);
    end
  endtask

  task automatic cyc(bit v, int m, logic [63:0] a, logic [63:0] b,
                     bit we, int wd, string tag);
    op_valid    = v;
    op_mode     = 2'(m);
    src_a       = a;
    src_b       = b;
    scale_we    = we;
    scale_wdata = 4'(wd);
    @(posedge clk);
    if (v) begin
      exp_vld = 1'b1;
      exp_res = model(m, a, b, m_scale);
    end else begin
      exp_vld = 1'b0;
    end
    if (we) m_scale = wd;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_scale(int s);
    cyc(1'b0, 0, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1, s, "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    scale_we = 1'b0; scale_wdata = '0; op_valid = 1'b0; op_mode = '0;
    src_a = '0; src_b = '0;
    m_scale = 0; exp_res = '0; exp_vld = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    src_a = 64'hFFFF_FFFF_FFFF_FFFF;
    op_valid = 1'b1;
    @(negedge clk);
    compare("R1");
    op_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R1 scale resets to 0; R4 basic pixel-16
    cyc(1'b1, 0, {16'd1280, 16'd256, 16'd200, 16'd0}, '0, 1'b0, 0, "R1");

    // R5 clamp edges, scale 0
    cyc(1'b1, 0, {16'sd32704, 16'sd32703, 16'sd32576, 16'sd32575}, '0, 1'b0, 0, "R5");
    cyc(1'b1, 0, {16'h8000, -16'sd65, -16'sd1, 16'sd63}, '0, 1'b0, 0, "R5");
    cyc(1'b1, 1, {32'h7F80_0000, 32'hFFFF_FFFF}, 64'h1122_3344_5566_7788, 1'b0, 0, "R5");
    cyc(1'b1, 1, {32'h7FBF_FFFF, 32'h8000_0000}, 64'hA5A5_A5A5_5A5A_5A5A, 1'b0, 0, "R5");

    // R8 exact halves
    cyc(1'b1, 0, {16'sd192, 16'sd191, -16'sd64, 16'sd64}, '0, 1'b0, 0, "R8");
    cyc(1'b1, 1, {32'h0040_0000, 32'h003F_FFFF}, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, "R8");
    cyc(1'b1, 2, {32'hFFFF_8000, 32'h0000_8000}, {32'h8000_0000, 32'h7FFF_7FFF}, 1'b0, 0, "R8");

    // R7 saturation
    set_scale(1);
    cyc(1'b1, 2, {32'h7FFF_8000, 32'h8000_0000}, {32'hC000_0000, 32'h3FFF_7FFF}, 1'b0, 0, "R7");

    // R3 write in same cycle as op: op keeps old scale (1), then new (6)
    cyc(1'b1, 0, {4{16'sd100}}, '0, 1'b1, 6, "R3");
    cyc(1'b1, 0, {4{16'sd100}}, '0, 1'b0, 0, "R3");

    // R2 idle cycles hold result with changing inputs
    for (int n = 0; n < 4; n++)
      cyc(1'b0, n, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 0, "R2");

    // R9 reserved mode
    cyc(1'b1, 3, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 0, "R9");

    // every scale, every mode
    for (int s = 0; s < 16; s++) begin
      set_scale(s);
      for (int n = 0; n < 4; n++) begin
        cyc(1'b1, 0, {$urandom, $urandom} & {4{16'h81FF}}, '0, 1'b0, 0, "R4");
        cyc(1'b1, 0, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 0, "R4");
        cyc(1'b1, 1, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 0, "R6");
        cyc(1'b1, 1, {$urandom, $urandom} & {2{32'h80FF_FFFF}}, {$urandom, $urandom}, 1'b0, 0, "R6");
        cyc(1'b1, 2, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 0, "R7");
        cyc(1'b1, 2, {$urandom, $urandom} & {2{32'h8003_FFFF}},
                     {$urandom, $urandom} & {2{32'h8003_FFFF}}, 1'b0, 0, "R7");
        cyc(1'b1, 3, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 0, "R9");
        cyc(1'b0, 1, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 0, "R2");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule